// File: doc/BRIEF.md
# Prioritized Reset Request Arbiter

The block arbitrates between a software-written subsystem reset request and a set of higher-priority reset sources. Software sets or clears a single request bit through a register write port. It reads the bit back together with a two-bit acknowledge code. The arbiter decides whether to accept or refuse the software request as soon as the bit is set. The code appears on the next clock edge. From then on the code never falls back to "no request" until software clears the bit.

A shared reset sequencer executes the resets. Higher-priority sources always reach the sequencer first. A higher-priority request can be granted: the reset output is pulsed, the arbiter waits for the external sequence-done indication, and then waits for that source to withdraw. It can also be refused: the arbiter holds a refusal indication until that source withdraws, and no reset is driven. In either case, an accepted software request that is still waiting is executed afterwards. A refused higher-priority source cannot cause an accepted software request to be lost.

An accepted software request cannot be cleared until its own reset has been pulsed and the done input has closed the sequence. A refused software request can be cleared at any time. After a clear, a new request may be written.

Top module: `rst_prio_arb`

## Requirements
- R1: After reset the request read-back is 0, the acknowledge code is 00, the reset output is low, and the grant and refusal vectors are all zero.
- R2: The acknowledge code is 00 for no request, 01 for accepted and 10 for refused; 11 is never produced.
- R3: Writing 1 to a clear request bit samples `sw_deny_en` in the write cycle. On the next edge the bit reads 1 and the code is 10 if deny was high, otherwise 01. While the bit reads 1 the code is never 00.
- R4: The request bit and its code stay unchanged until software writes 0. Writing 1 to a bit that is already set is ignored, and the request is not evaluated again.
- R5: A write of 0 is ignored while an accepted software reset has not yet completed. A write of 0 to a refused request, or to an accepted request that has completed, returns the bit to 0 and the code to 00 on the next edge. A new request may then be written.
- R6: When several higher-priority sources request at once while the sequencer is idle, the lowest index is served first (default `LOW_INDEX_FIRST=1`). At most one bit across `hi_gnt` and `hi_dny` is ever set.
- R7: A higher-priority request present while the sequencer is idle is served before an accepted software reset that is waiting, including when both arrive in the same cycle.
- R8: Every accepted reset drives `rst_out` high for exactly `ASSERT_CYCLES` consecutive cycles. The sequencer then waits for `seq_done`. `seq_done` has no effect at any other time.
- R9: A served higher-priority source whose `hi_deny` bit is high gets its `hi_dny` bit set and no reset, until it withdraws. An accepted software request written meanwhile keeps code 01 throughout and is executed afterwards.
- R10: After `seq_done` closes a granted higher-priority reset, `hi_gnt` stays set and nothing else is served until that source drops its request.
- R11: A refused software request never causes `rst_out` to be driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Register write strobe for the request bit |
| sw_wr_data | input | 1 | Value written to the request bit |
| sw_deny_en | input | 1 | Refuse the software request evaluated in this cycle |
| hi_req | input | NUM_HI | Higher-priority reset requests |
| hi_deny | input | NUM_HI | Per-source refusal of higher-priority requests |
| seq_done | input | 1 | External reset sequence has completed |
| sw_req_rd | output | 1 | Read-back of the software request bit |
| sw_ack | output | 2 | Acknowledge code: 00 none, 01 accepted, 10 refused |
| rst_out | output | 1 | Reset drive to the subsystem |
| hi_gnt | output | NUM_HI | One-hot: higher-priority source being reset |
| hi_dny | output | NUM_HI | One-hot: higher-priority source being refused |

## Verification
On every cycle the assertions check the following: the reserved code never appears, the code is nonzero and stable while the bit is set, the bit is cleared only by a write of 0, each reset pulse has exactly the configured length, the grant and refusal vectors stay one-hot, and no reset is driven while a source is being refused or for a refused software request. Ordering properties need directed scenarios in the bench, which compares the arbiter against a behavioural model on every clock. These are: a software request surviving a refused source that arrived in the same cycle, a software reset waiting behind a granted source until that source withdraws, lowest-index priority, and clears ignored before completion.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_HOLD,
      SQ_PULSE,
      SQ_WAIT,
      SQ_RELEASE
   } seq_state_e;

   localparam logic [1:0] ACK_NONE   = 2'b00;
   localparam logic [1:0] ACK_GRANT  = 2'b01;
   localparam logic [1:0] ACK_REFUSE = 2'b10;
endpackage

// File: rtl/rpa_pick.sv
module rpa_pick #(
   parameter int NUM_HI          = 2,
   parameter bit LOW_INDEX_FIRST = 1'b1,
   localparam int IDXW           = (NUM_HI > 1) ? $clog2(NUM_HI) : 1
) (
   input  logic [NUM_HI-1:0] req,
   output logic              any,
   output logic [IDXW-1:0]   idx
);
   assign any = |req;

   generate
      if (LOW_INDEX_FIRST) begin : g_low_first
         always_comb begin
            idx = '0;
            for (int i = NUM_HI - 1; i >= 0; i--) begin
               if (req[i]) idx = IDXW'(i);
            end
         end
      end else begin : g_high_first
         always_comb begin
            idx = '0;
            for (int i = 0; i < NUM_HI; i++) begin
               if (req[i]) idx = IDXW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rpa_sw_req.sv
module rpa_sw_req
   import rpa_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_data,
   input  logic       deny_en,
   input  logic       sw_done,
   output logic       req_q,
   output logic [1:0] ack_q,
   output logic       run_pend
);
   logic set_ok;
   logic clr_ok;

   assign set_ok = wr_en && wr_data && !req_q;
   assign clr_ok = wr_en && !wr_data && req_q && !run_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q    <= 1'b0;
         ack_q    <= ACK_NONE;
         run_pend <= 1'b0;
      end else begin
         if (set_ok) begin
            req_q    <= 1'b1;
            ack_q    <= deny_en ? ACK_REFUSE : ACK_GRANT;
            run_pend <= !deny_en;
         end else if (clr_ok) begin
            req_q <= 1'b0;
            ack_q <= ACK_NONE;
         end
         if (sw_done) run_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/rpa_seq.sv
module rpa_seq
   import rpa_pkg::*;
#(
   parameter int NUM_HI          = 2,
   parameter int ASSERT_CYCLES   = 4,
   parameter bit LOW_INDEX_FIRST = 1'b1,
   localparam int IDXW           = (NUM_HI > 1) ? $clog2(NUM_HI) : 1,
   localparam int CW             = (ASSERT_CYCLES > 1) ? $clog2(ASSERT_CYCLES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_HI-1:0] hi_req,
   input  logic [NUM_HI-1:0] hi_deny,
   input  logic              run_pend,
   input  logic              seq_done,
   output logic              rst_out,
   output logic [NUM_HI-1:0] hi_gnt,
   output logic [NUM_HI-1:0] hi_dny,
   output logic              sw_done
);
   localparam logic [CW-1:0] CNT_LAST = CW'(ASSERT_CYCLES - 1);

   seq_state_e      state_q;
   logic [IDXW-1:0] sel_q;
   logic            owner_hi_q;
   logic [CW-1:0]   cnt_q;
   logic            pick_any;
   logic [IDXW-1:0] pick_idx;
   logic            hi_busy;

   rpa_pick #(
      .NUM_HI          (NUM_HI),
      .LOW_INDEX_FIRST (LOW_INDEX_FIRST)
   ) u_pick (
      .req (hi_req),
      .any (pick_any),
      .idx (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         sel_q      <= '0;
         owner_hi_q <= 1'b0;
         cnt_q      <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (pick_any) begin
                  sel_q <= pick_idx;
                  if (hi_deny[pick_idx]) begin
                     state_q <= SQ_HOLD;
                  end else begin
                     state_q    <= SQ_PULSE;
                     owner_hi_q <= 1'b1;
                     cnt_q      <= '0;
                  end
               end else if (run_pend) begin
                  state_q    <= SQ_PULSE;
                  owner_hi_q <= 1'b0;
                  cnt_q      <= '0;
               end
            end
            SQ_HOLD: begin
               if (!hi_req[sel_q]) state_q <= SQ_IDLE;
            end
            SQ_PULSE: begin
               if (cnt_q == CNT_LAST) state_q <= SQ_WAIT;
               else                   cnt_q   <= cnt_q + 1'b1;
            end
            SQ_WAIT: begin
               if (seq_done) state_q <= owner_hi_q ? SQ_RELEASE : SQ_IDLE;
            end
            SQ_RELEASE: begin
               if (!hi_req[sel_q]) state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign rst_out = (state_q == SQ_PULSE);
   assign hi_busy = owner_hi_q &&
                    ((state_q == SQ_PULSE) || (state_q == SQ_WAIT) || (state_q == SQ_RELEASE));
   assign sw_done = (state_q == SQ_WAIT) && !owner_hi_q && seq_done;

   generate
      for (genvar i = 0; i < NUM_HI; i++) begin : g_flags
         assign hi_gnt[i] = hi_busy && (sel_q == IDXW'(i));
         assign hi_dny[i] = (state_q == SQ_HOLD) && (sel_q == IDXW'(i));
      end
   endgenerate
endmodule

// File: rtl/rst_prio_arb.sv
module rst_prio_arb #(
   parameter int NUM_HI          = 2,
   parameter int ASSERT_CYCLES   = 4,
   parameter bit LOW_INDEX_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr_en,
   input  logic              sw_wr_data,
   input  logic              sw_deny_en,
   input  logic [NUM_HI-1:0] hi_req,
   input  logic [NUM_HI-1:0] hi_deny,
   input  logic              seq_done,
   output logic              sw_req_rd,
   output logic [1:0]        sw_ack,
   output logic              rst_out,
   output logic [NUM_HI-1:0] hi_gnt,
   output logic [NUM_HI-1:0] hi_dny
);
   generate
      if (NUM_HI < 1) begin : g_bad_num_hi
         $error("rst_prio_arb: NUM_HI must be at least 1");
      end
      if (ASSERT_CYCLES < 1) begin : g_bad_cycles
         $error("rst_prio_arb: ASSERT_CYCLES must be at least 1");
      end
   endgenerate

   logic run_pend;
   logic sw_done;

   rpa_sw_req u_sw (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sw_wr_en),
      .wr_data  (sw_wr_data),
      .deny_en  (sw_deny_en),
      .sw_done  (sw_done),
      .req_q    (sw_req_rd),
      .ack_q    (sw_ack),
      .run_pend (run_pend)
   );

   rpa_seq #(
      .NUM_HI          (NUM_HI),
      .ASSERT_CYCLES   (ASSERT_CYCLES),
      .LOW_INDEX_FIRST (LOW_INDEX_FIRST)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi_req   (hi_req),
      .hi_deny  (hi_deny),
      .run_pend (run_pend),
      .seq_done (seq_done),
      .rst_out  (rst_out),
      .hi_gnt   (hi_gnt),
      .hi_dny   (hi_dny),
      .sw_done  (sw_done)
   );
endmodule

// File: rtl/rpa_chk.sv
module rpa_chk #(
   parameter int NUM_HI        = 2,
   parameter int ASSERT_CYCLES = 4,
   localparam int RCW          = $clog2(ASSERT_CYCLES + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_wr_en,
   input logic              sw_wr_data,
   input logic              sw_req_rd,
   input logic [1:0]        sw_ack,
   input logic              rst_out,
   input logic [NUM_HI-1:0] hi_gnt,
   input logic [NUM_HI-1:0] hi_dny
);
   localparam logic [RCW-1:0] RC_FULL = RCW'(ASSERT_CYCLES);
   localparam logic [RCW-1:0] RC_SAT  = RCW'(ASSERT_CYCLES + 1);

   logic [RCW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             run_len <= '0;
      else if (!rst_out)                      run_len <= '0;
      else if (run_len != RC_SAT)             run_len <= run_len + 1'b1;
   end

   AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_ack != 2'b11); // R2
   AST_CODE_WHILE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req_rd |-> (sw_ack != 2'b00)); // R3
   AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req_rd |=> (!sw_req_rd || $stable(sw_ack))); // R4
   AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req_rd && !(sw_wr_en && !sw_wr_data)) |=> sw_req_rd); // R5
   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hi_gnt, hi_dny})); // R6
   AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= RC_FULL); // R8
   AST_PULSE_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_out && (run_len != '0)) |-> (run_len == RC_FULL)); // R8
   AST_NO_RESET_WHEN_REFUSING: assert property (@(posedge clk) disable iff (!rst_n)
      (|hi_dny) |-> !rst_out); // R9
   AST_REFUSED_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_out && (hi_gnt == '0)) |-> (sw_ack == 2'b01)); // R11
endmodule

bind rst_prio_arb rpa_chk #(
   .NUM_HI        (NUM_HI),
   .ASSERT_CYCLES (ASSERT_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_wr_en   (sw_wr_en),
   .sw_wr_data (sw_wr_data),
   .sw_req_rd  (sw_req_rd),
   .sw_ack     (sw_ack),
   .rst_out    (rst_out),
   .hi_gnt     (hi_gnt),
   .hi_dny     (hi_dny)
);

// File: tb/rst_prio_arb_test.sv
`timescale 1ns/1ps
module rst_prio_arb_test;
   localparam int NH  = 2;
   localparam int CYC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_wr_en = 1'b0;
   logic          sw_wr_data = 1'b0;
   logic          sw_deny_en = 1'b0;
   logic [NH-1:0] hi_req = '0;
   logic [NH-1:0] hi_deny = '0;
   logic          seq_done = 1'b0;
   logic          sw_req_rd;
   logic [1:0]    sw_ack;
   logic          rst_out;
   logic [NH-1:0] hi_gnt;
   logic [NH-1:0] hi_dny;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rst_prio_arb #(.NUM_HI(NH), .ASSERT_CYCLES(CYC), .LOW_INDEX_FIRST(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
      .sw_deny_en(sw_deny_en), .hi_req(hi_req), .hi_deny(hi_deny), .seq_done(seq_done),
      .sw_req_rd(sw_req_rd), .sw_ack(sw_ack), .rst_out(rst_out), .hi_gnt(hi_gnt), .hi_dny(hi_dny)
   );

   // Behavioural reference: 0 idle, 1 refusing, 2 pulsing, 3 awaiting done, 4 awaiting withdrawal
   int m_req, m_ack, m_run, m_state, m_sel, m_hi_owner, m_cnt;
   bit m_valid = 1'b0;

   always @(posedge clk) begin : model
      int n_req, n_ack, n_run, n_state, n_sel, n_own, n_cnt;
      if (!rst_n) begin
         m_req = 0; m_ack = 0; m_run = 0; m_state = 0; m_sel = 0; m_hi_owner = 0; m_cnt = 0;
         m_valid = 1'b1;
      end else begin
         n_req = m_req; n_ack = m_ack; n_run = m_run; n_state = m_state;
         n_sel = m_sel; n_own = m_hi_owner; n_cnt = m_cnt;
         if (sw_wr_en && sw_wr_data && m_req == 0) begin
            n_req = 1; n_ack = sw_deny_en ? 2 : 1; n_run = sw_deny_en ? 0 : 1;
         end else if (sw_wr_en && !sw_wr_data && m_req == 1 && m_run == 0) begin
            n_req = 0; n_ack = 0;
         end
         if (m_state == 3 && m_hi_owner == 0 && seq_done) n_run = 0;
         case (m_state)
            0: begin
               if (hi_req != 0) begin
                  n_sel = hi_req[0] ? 0 : 1;
                  if (hi_deny[n_sel]) n_state = 1;
                  else begin n_state = 2; n_own = 1; n_cnt = 0; end
               end else if (m_run == 1) begin
                  n_state = 2; n_own = 0; n_cnt = 0;
               end
            end
            1: if (!hi_req[m_sel]) n_state = 0;
            2: if (m_cnt == CYC - 1) n_state = 3; else n_cnt = m_cnt + 1;
            3: if (seq_done) n_state = (m_hi_owner == 1) ? 4 : 0;
            4: if (!hi_req[m_sel]) n_state = 0;
            default: n_state = 0;
         endcase
         m_req = n_req; m_ack = n_ack; m_run = n_run; m_state = n_state;
         m_sel = n_sel; m_hi_owner = n_own; m_cnt = n_cnt;
      end
   end

   always @(negedge clk) begin : compare
      logic [1:0]    e_ack;
      logic          e_rst;
      logic [NH-1:0] e_gnt, e_dny;
      if (m_valid && !finished) begin
         e_ack = 2'(m_ack);
         e_rst = (m_state == 2);
         e_gnt = (m_hi_owner == 1 && m_state >= 2) ? NH'(1 << m_sel) : '0;
         e_dny = (m_state == 1) ? NH'(1 << m_sel) : '0;
         n_cmp++;
         if (sw_req_rd !== 1'(m_req) || sw_ack !== e_ack || rst_out !== e_rst ||
             hi_gnt !== e_gnt || hi_dny !== e_dny) begin
            n_bad++;
            if (sw_req_rd !== 1'(m_req)) $display("FAIL R4 model req actual=%0b expected=%0d", sw_req_rd, m_req);
            if (sw_ack !== e_ack)   $display("FAIL R3 model ack actual=%b expected=%b", sw_ack, e_ack);
            if (rst_out !== e_rst)  $display("FAIL R8 model rst_out actual=%b expected=%b", rst_out, e_rst);
            if (hi_gnt !== e_gnt)   $display("FAIL R6 model hi_gnt actual=%b expected=%b", hi_gnt, e_gnt);
            if (hi_dny !== e_dny)   $display("FAIL R9 model hi_dny actual=%b expected=%b", hi_dny, e_dny);
         end
      end
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sw_write(input logic v, input logic deny);
      sw_wr_en = 1'b1; sw_wr_data = v; sw_deny_en = deny;
      step(1);
      sw_wr_en = 1'b0; sw_wr_data = 1'b0; sw_deny_en = 1'b0;
   endtask

   task automatic pulse_done();
      seq_done = 1'b1;
      step(1);
      seq_done = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin : stim
      step(3);
      // R1: reset values
      check("R1 req", 8'(sw_req_rd), 8'h0);
      check("R1 ack", 8'(sw_ack), 8'h0);
      check("R1 rst/gnt/dny", 8'({rst_out, hi_gnt, hi_dny}), 8'h0);
      rst_n = 1'b1;
      step(2);

      // R3 accepted software request, R5 clear ignored until completion, R8 pulse
      sw_write(1'b1, 1'b0);
      check("R3 ack accepted", 8'(sw_ack), 8'h1);
      step(1);
      check("R8 pulse start", 8'(rst_out), 8'h1);
      pulse_done();                       // R8: done during pulse ignored
      sw_write(1'b0, 1'b0);               // R5: clear ignored while pending
      check("R5 clear ignored", 8'(sw_req_rd), 8'h1);
      step(2);
      check("R8 pulse ended", 8'(rst_out), 8'h0);
      step(3);
      check("R8 waits for done", 8'(sw_ack), 8'h1);
      pulse_done();
      sw_write(1'b0, 1'b0);
      check("R5 clear after done", 8'({sw_req_rd, sw_ack}), 8'h0);
      pulse_done();                       // R8: done while idle ignored
      step(2);

      // R11 refused software request; R4 rewrite ignored
      sw_write(1'b1, 1'b1);
      check("R2 ack refused", 8'(sw_ack), 8'h2);
      sw_write(1'b1, 1'b0);
      check("R4 rewrite ignored", 8'(sw_ack), 8'h2);
      step(6);
      check("R11 no reset", 8'(rst_out), 8'h0);
      sw_write(1'b0, 1'b0);
      check("R5 clear refused", 8'({sw_req_rd, sw_ack}), 8'h0);

      // R9 refused source arriving together with software request
      hi_req = 2'b01; hi_deny = 2'b01;
      sw_write(1'b1, 1'b0);
      step(5);
      check("R9 ack kept", 8'(sw_ack), 8'h1);
      check("R9 refusal shown", 8'(hi_dny), 8'h1);
      check("R9 no reset", 8'(rst_out), 8'h0);
      hi_req = 2'b00; hi_deny = 2'b00;
      step(2);
      check("R9 sw executed", 8'({rst_out, hi_gnt}), 8'h4);
      step(4);
      pulse_done();
      sw_write(1'b0, 1'b0);
      check("R9 cleared", 8'(sw_ack), 8'h0);

      // R7 granted source first, R10 hold until withdrawal
      hi_req = 2'b10;
      sw_write(1'b1, 1'b0);
      check("R7 hi first", 8'({rst_out, hi_gnt}), 8'h6);
      step(4);
      pulse_done();
      step(3);
      check("R10 no reset yet", 8'(rst_out), 8'h0);
      check("R10 grant held", 8'(hi_gnt), 8'h2);
      hi_req = 2'b00;
      step(2);
      check("R7 sw after hi", 8'({rst_out, hi_gnt}), 8'h4);
      step(4);
      pulse_done();
      sw_write(1'b0, 1'b0);

      // R6 lowest index wins
      hi_req = 2'b11;
      step(1);
      check("R6 priority", 8'(hi_gnt), 8'h1);
      step(4);
      pulse_done();
      hi_req = 2'b10;
      step(2);
      check("R6 next source", 8'(hi_gnt), 8'h2);
      step(4);
      pulse_done();
      hi_req = 2'b00;
      step(3);
      check("R1 idle again", 8'({rst_out, hi_gnt, hi_dny}), 8'h0);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule